// File: doc/BRIEF.md
# Write-Through Cache with IO Bypass

This block sits between a processor memory port and a downstream memory port. Instruction fetches and data reads look up one of two separate arrays of identical geometry. A hit answers on the next cycle. A miss fetches the whole line from downstream, one word at a time in ascending order, and stores it in the way that the set's round-robin pointer selects. Writes never allocate. Each write is first sent downstream. If that write succeeds and the line is present, only the enabled bytes of the cached copy are updated.

An address is treated as IO when the address ANDed with `IO_MASK` equals `IO_BASE`. IO accesses bypass both arrays in both directions. The set index is taken from the address masked to the cache size and shifted right by log2(line bytes × ways). The stored tag is the address shifted right by log2(line bytes). As a result, neighbouring lines can share a set. The block handles one request at a time. Downstream errors are returned unchanged in the response.

Top module: `wtc_cache`

## Requirements
- R1: After reset every line of both arrays is invalid. `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_req_o` is 0. The first read of any line misses.
- R2: A non-IO read miss issues LINE_BYTES/4 downstream reads. They start at the line base address and rise in steps of 4. The response carries the downstream word at the requested word offset (address bits [5:2] for the default 64-byte line).
- R3: A non-IO read hit responds one cycle after acceptance with the stored word and makes no downstream request.
- R4: Every write produces exactly one downstream write with the same address, data and byte enables (bit i of `req_be_i` covers data bits 8i+7..8i). The response follows downstream completion, and `rsp_err_o` equals the downstream error flag.
- R5: A successful write that hits updates only the enabled bytes of the cached word.
- R6: A write that misses does not allocate a line. A later read of that line misses.
- R7: A write whose downstream response reports an error leaves the cached copy unchanged.
- R8: For an IO address ((addr & 32'hF000_0000) == 32'hF000_0000 by default), every read makes one downstream read and allocates nothing, and writes never touch an array.
- R9: Instruction accesses (`req_instr_i`=1) and data accesses (`req_instr_i`=0) use separate arrays. A line filled on one side misses on the other.
- R10: The set index is (addr & (SIZE_BYTES-1)) >> log2(LINE_BYTES×WAYS), which is bits [11:7] by default. A per-set round-robin pointer starts at way 0 and advances after each completed fill. It picks the victim, so the third distinct line filled into a two-way set evicts the first.
- R11: A downstream error during a line fill ends the fill at once with `rsp_err_o`=1. The line stays invalid.
- R12: A downstream error on an IO read is returned with `rsp_err_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_valid_i | input | 1 | request present |
| req_ready_o | output | 1 | block idle, request taken on this edge |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_instr_i | input | 1 | 1 = instruction side, 0 = data side |
| req_addr_i | input | ADDR_W | word-aligned byte address |
| req_wdata_i | input | DATA_W | write data |
| req_be_i | input | DATA_W/8 | write byte enables |
| rsp_valid_o | output | 1 | one-cycle response strobe |
| rsp_rdata_o | output | DATA_W | read data |
| rsp_err_o | output | 1 | downstream error |
| mem_req_o | output | 1 | downstream request, held until `mem_rsp_i` |
| mem_write_o | output | 1 | downstream write |
| mem_addr_o | output | ADDR_W | downstream address |
| mem_wdata_o | output | DATA_W | downstream write data |
| mem_be_o | output | DATA_W/8 | downstream byte enables |
| mem_rsp_i | input | 1 | downstream completion |
| mem_rdata_i | input | DATA_W | downstream read data |
| mem_err_i | input | 1 | downstream error |

## Verification
The assertions check several rules on every cycle. A read hit answers on the next cycle without any downstream request. A downstream request holds its address and direction until it completes. Fills advance word by word, are always reads, and never touch the IO window. A response appears only while the block is idle. Other behaviour needs the bench's scenarios, because it depends on what earlier accesses left in the arrays. These cases are the byte merge on a write hit, the absence of allocation on write misses and failed writes, the separation of instruction and data contents, round-robin eviction order inside a set, and the invalid state left behind by an aborted fill. The bench exposes stale data by changing its memory model behind the cache.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_FILL} wtc_state_e;
  localparam int unsigned N_SIDES = 2; // 0 data, 1 instruction
endpackage

// File: rtl/wtc_io_decode.sv
module wtc_io_decode #(
  parameter int unsigned           ADDR_W  = 32,
  parameter logic [ADDR_W-1:0]     IO_BASE = 32'hF000_0000,
  parameter logic [ADDR_W-1:0]     IO_MASK = 32'hF000_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_io_o
);
  assign is_io_o = (addr_i & IO_MASK) == IO_BASE;
endmodule

// File: rtl/wtc_array.sv
module wtc_array #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SIZE_BYTES = 4096,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned WAYS       = 2,
  localparam int unsigned WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   lk_addr_i,
  output logic                lk_hit_o,
  output logic [WAY_W-1:0]    lk_way_o,
  output logic [DATA_W-1:0]   lk_rdata_o,
  output logic [WAY_W-1:0]    lk_victim_o,
  input  logic                inv_i,
  input  logic [WAY_W-1:0]    inv_way_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [WAY_W-1:0]    wr_way_i,
  input  logic [DATA_W/8-1:0] wr_be_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                validate_i
);
  localparam int unsigned BE_W     = DATA_W / 8;
  localparam int unsigned WORD_OFF = $clog2(BE_W);
  localparam int unsigned OFF_W    = $clog2(LINE_BYTES);
  localparam int unsigned WPL      = LINE_BYTES / BE_W;
  localparam int unsigned WIDX_W   = (OFF_W > WORD_OFF) ? OFF_W - WORD_OFF : 1;
  localparam int unsigned SETS     = SIZE_BYTES / (LINE_BYTES * WAYS);
  localparam int unsigned SET_SH   = $clog2(LINE_BYTES * WAYS);
  localparam int unsigned SET_W    = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int unsigned TAG_W    = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] SZ_MASK = ADDR_W'(SIZE_BYTES - 1);

  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAY_W-1:0]  rr_q    [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [DATA_W-1:0] data_q  [SETS][WAYS][WPL];

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = (a & SZ_MASK) >> SET_SH;
    return m[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [WIDX_W-1:0] widx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:WORD_OFF];
  endfunction

  logic [SET_W-1:0]  lk_set, wr_set;
  logic [TAG_W-1:0]  lk_tag;
  logic [WIDX_W-1:0] lk_widx, wr_widx;
  logic [WAY_W-1:0]  rr_next;

  assign lk_set  = set_of(lk_addr_i);
  assign lk_tag  = tag_of(lk_addr_i);
  assign lk_widx = widx_of(lk_addr_i);
  assign wr_set  = set_of(wr_addr_i);
  assign wr_widx = widx_of(wr_addr_i);
  assign rr_next = (rr_q[wr_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[wr_set] + 1'b1;

  always_comb begin
    lk_hit_o = 1'b0;
    lk_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
        lk_hit_o = 1'b1;
        lk_way_o = WAY_W'(w);
      end
    end
  end

  assign lk_rdata_o  = data_q[lk_set][lk_way_o][lk_widx];
  assign lk_victim_o = rr_q[lk_set];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      if (inv_i) valid_q[lk_set][inv_way_i] <= 1'b0;
      if (validate_i) begin
        valid_q[wr_set][wr_way_i] <= 1'b1;
        rr_q[wr_set]              <= rr_next;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (validate_i) tag_q[wr_set][wr_way_i] <= tag_of(wr_addr_i);
    if (wr_en_i) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be_i[b]) data_q[wr_set][wr_way_i][wr_widx][8*b +: 8] <= wr_data_i[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache #(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       SIZE_BYTES = 4096,
  parameter int unsigned       LINE_BYTES = 64,
  parameter int unsigned       WAYS       = 2,
  parameter logic [ADDR_W-1:0] IO_BASE    = 32'hF000_0000,
  parameter logic [ADDR_W-1:0] IO_MASK    = 32'hF000_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic                req_instr_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                rsp_err_o,
  output logic                mem_req_o,
  output logic                mem_write_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  input  logic                mem_rsp_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                mem_err_i
);
  import wtc_pkg::*;

  localparam int unsigned BE_W     = DATA_W / 8;
  localparam int unsigned WORD_OFF = $clog2(BE_W);
  localparam int unsigned OFF_W    = $clog2(LINE_BYTES);
  localparam int unsigned WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;

  wtc_state_e        state_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [DATA_W-1:0] wdata_q, cap_q, rsp_rdata_q;
  logic [BE_W-1:0]   be_q;
  logic              write_q, side_q, io_q, hit_q, rsp_valid_q, rsp_err_q;
  logic [WAY_W-1:0]  hit_way_q, vict_q;
  logic [WORD_OFF+OFF_W-WORD_OFF-1:WORD_OFF] req_widx_q;

  logic              lk_hit   [N_SIDES];
  logic [WAY_W-1:0]  lk_way   [N_SIDES];
  logic [WAY_W-1:0]  lk_vict  [N_SIDES];
  logic [DATA_W-1:0] lk_rdata [N_SIDES];

  logic req_io, accept, rd_hit_acc, fill_miss, in_fill, fill_last;
  logic fill_we, upd_we, validate, widx_match;

  wtc_io_decode #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)) u_io_req (
    .addr_i (req_addr_i),
    .is_io_o(req_io)
  );

  assign accept     = req_valid_i && state_q == ST_IDLE;
  assign rd_hit_acc = accept && !req_write_i && !req_io && lk_hit[req_instr_i];
  assign fill_miss  = accept && !req_write_i && !req_io && !lk_hit[req_instr_i];
  assign in_fill    = state_q == ST_FILL;
  assign fill_last  = &mem_addr_q[OFF_W-1:WORD_OFF];
  assign widx_match = mem_addr_q[OFF_W-1:WORD_OFF] == req_widx_q;
  assign fill_we    = in_fill && mem_rsp_i && !mem_err_i;
  assign validate   = fill_we && fill_last;
  assign upd_we     = state_q == ST_MEM && mem_rsp_i && write_q && !mem_err_i && !io_q && hit_q;

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    logic on_req, on_cur;
    assign on_req = req_instr_i == 1'(s);
    assign on_cur = side_q == 1'(s);
    wtc_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_BYTES(SIZE_BYTES),
      .LINE_BYTES(LINE_BYTES), .WAYS(WAYS)
    ) u_arr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lk_addr_i  (req_addr_i),
      .lk_hit_o   (lk_hit[s]),
      .lk_way_o   (lk_way[s]),
      .lk_rdata_o (lk_rdata[s]),
      .lk_victim_o(lk_vict[s]),
      .inv_i      (fill_miss && on_req),
      .inv_way_i  (lk_vict[s]),
      .wr_en_i    ((fill_we || upd_we) && on_cur),
      .wr_addr_i  (mem_addr_q),
      .wr_way_i   (in_fill ? vict_q : hit_way_q),
      .wr_be_i    (in_fill ? {BE_W{1'b1}} : be_q),
      .wr_data_i  (in_fill ? mem_rdata_i : wdata_q),
      .validate_i (validate && on_cur)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mem_addr_q  <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      write_q     <= 1'b0;
      side_q      <= 1'b0;
      io_q        <= 1'b0;
      hit_q       <= 1'b0;
      hit_way_q   <= '0;
      vict_q      <= '0;
      req_widx_q  <= '0;
      cap_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          side_q     <= req_instr_i;
          write_q    <= req_write_i;
          wdata_q    <= req_wdata_i;
          be_q       <= req_write_i ? req_be_i : {BE_W{1'b1}};
          io_q       <= req_io;
          hit_q      <= lk_hit[req_instr_i];
          hit_way_q  <= lk_way[req_instr_i];
          vict_q     <= lk_vict[req_instr_i];
          req_widx_q <= req_addr_i[OFF_W-1:WORD_OFF];
          if (rd_hit_acc) begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= lk_rdata[req_instr_i];
            rsp_err_q   <= 1'b0;
          end else if (fill_miss) begin
            mem_addr_q <= {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            state_q    <= ST_FILL;
          end else begin
            mem_addr_q <= req_addr_i;
            state_q    <= ST_MEM;
          end
        end
        ST_MEM: if (mem_rsp_i) begin
          rsp_valid_q <= 1'b1;
          rsp_rdata_q <= mem_rdata_i;
          rsp_err_q   <= mem_err_i;
          state_q     <= ST_IDLE;
        end
        ST_FILL: if (mem_rsp_i) begin
          if (mem_err_i) begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= mem_rdata_i;
            rsp_err_q   <= 1'b1;
            state_q     <= ST_IDLE;
          end else begin
            if (widx_match) cap_q <= mem_rdata_i;
            if (fill_last) begin
              rsp_valid_q <= 1'b1;
              rsp_rdata_q <= widx_match ? mem_rdata_i : cap_q;
              rsp_err_q   <= 1'b0;
              state_q     <= ST_IDLE;
            end else begin
              mem_addr_q <= mem_addr_q + ADDR_W'(BE_W);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = state_q == ST_IDLE;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_err_o   = rsp_err_q;
  assign mem_req_o   = state_q != ST_IDLE;
  assign mem_write_o = state_q == ST_MEM && write_q;
  assign mem_addr_o  = mem_addr_q;
  assign mem_wdata_o = wdata_q;
  assign mem_be_o    = be_q;
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int unsigned       ADDR_W  = 32,
  parameter int unsigned       BE_W    = 4,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'hF000_0000,
  parameter logic [ADDR_W-1:0] IO_MASK = 32'hF000_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              mem_req_o,
  input logic              mem_write_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rsp_i,
  input logic              mem_err_i,
  input logic              rd_hit_acc,
  input logic              in_fill,
  input logic              fill_last
);
  p_hit_fast_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_acc |=> rsp_valid_o && !mem_req_o);

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rsp_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_write_o));

  p_rsp_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);

  p_fill_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fill && mem_rsp_i && !mem_err_i && !fill_last |=> in_fill && mem_addr_o == $past(mem_addr_o) + ADDR_W'(BE_W));

  p_fill_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fill |-> mem_req_o && !mem_write_o);

  p_io_no_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fill |-> (mem_addr_o & IO_MASK) != IO_BASE);
endmodule

bind wtc_cache wtc_checker #(
  .ADDR_W(ADDR_W), .BE_W(BE_W), .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .mem_req_o  (mem_req_o),
  .mem_write_o(mem_write_o),
  .mem_addr_o (mem_addr_o),
  .mem_rsp_i  (mem_rsp_i),
  .mem_err_i  (mem_err_i),
  .rd_hit_acc (rd_hit_acc),
  .in_fill    (in_fill),
  .fill_last  (fill_last)
);

// File: tb/wtc_cache_tb.sv
module wtc_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_instr = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mem_req, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_rsp = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  wtc_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_instr_i(req_instr), .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .mem_req_o(mem_req), .mem_write_o(mem_write), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .mem_rsp_i(mem_rsp), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err)
  );

  int n_run = 0, n_fail = 0, mem_cnt = 0;
  bit done = 1'b0;
  logic [31:0] err_addr = 32'h0000_0001;
  logic [31:0] mem [logic [31:0]];

  typedef struct { bit chk; logic [31:0] d; bit e; string req; } exp_t;
  exp_t sb_q[$];

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // downstream model: one wait cycle, then a one-cycle response
  int wcnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp <= 1'b0;
      wcnt    <= 0;
    end else if (mem_rsp) begin
      mem_rsp <= 1'b0;
    end else if (mem_req) begin
      if (wcnt == 1) begin
        logic e;
        logic [31:0] v;
        e = (mem_addr == err_addr);
        v = rd(mem_addr);
        mem_rsp   <= 1'b1;
        mem_err   <= e;
        mem_rdata <= v;
        if (mem_write && !e) begin
          for (int b = 0; b < 4; b++) if (mem_be[b]) v[8*b +: 8] = mem_wdata[8*b +: 8];
          mem[mem_addr] = v;
        end
        mem_cnt++;
        wcnt <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R4 unexpected response", rsp_rdata, '0);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        check(rsp_err == it.e, {it.req, " err"}, 32'(rsp_err), 32'(it.e));
        if (it.chk && !it.e) check(rsp_rdata == it.d, {it.req, " data"}, rsp_rdata, it.d);
      end
    end
  end

  task automatic acc(input bit wr, input bit ins, input logic [31:0] a, input logic [31:0] wd,
                     input logic [3:0] be, input bit chk, input logic [31:0] ed, input bit ee,
                     input int ecnt, input string req);
    exp_t it;
    int c0;
    it.chk = chk; it.d = ed; it.e = ee; it.req = req;
    sb_q.push_back(it);
    c0 = mem_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_instr = ins; req_addr = a; req_wdata = wd; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    check(mem_cnt - c0 == ecnt, {req, " downstream count"}, 32'(mem_cnt - c0), 32'(ecnt));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    logic [31:0] v100, o104, o108, m108, o10c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1 rsp", 32'(rsp_valid), 32'd0);
    check(mem_req == 1'b0, "R1 memreq", 32'(mem_req), 32'd0);

    // R1/R2 first read misses and fills 16 words
    v100 = rd(32'h100);
    acc(0, 0, 32'h100, '0, 4'h0, 1, v100, 0, 16, "R1 R2 miss fill");
    // R3 hits
    acc(0, 0, 32'h13C, '0, 4'h0, 1, rd(32'h13C), 0, 0, "R3 hit last word");
    o104 = rd(32'h104);
    mem[32'h104] = 32'hDEAD_BEEF;
    acc(0, 0, 32'h104, '0, 4'h0, 1, o104, 0, 0, "R3 stale hit");
    // R9 separate arrays
    acc(0, 1, 32'h104, '0, 4'h0, 1, 32'hDEAD_BEEF, 0, 16, "R9 instr miss");
    acc(0, 0, 32'h104, '0, 4'h0, 1, o104, 0, 0, "R9 data side kept");

    // R4/R5 write hit with byte enables
    o108 = rd(32'h108);
    acc(1, 0, 32'h108, 32'h1122_3344, 4'b0011, 0, '0, 0, 1, "R4 write hit");
    m108 = {o108[31:16], 16'h3344};
    check(rd(32'h108) == m108, "R4 downstream data", rd(32'h108), m108);
    acc(0, 0, 32'h108, '0, 4'h0, 1, m108, 0, 0, "R5 merged hit");

    // R6 write miss no allocate
    acc(1, 0, 32'h2000, 32'hAABB_CCDD, 4'hF, 0, '0, 0, 1, "R6 write miss");
    acc(0, 0, 32'h2000, '0, 4'h0, 1, 32'hAABB_CCDD, 0, 16, "R6 read misses");

    // R7 failed write leaves cache
    o10c = rd(32'h10C);
    err_addr = 32'h10C;
    acc(1, 0, 32'h10C, 32'h1234_5678, 4'hF, 0, '0, 1, 1, "R7 write error");
    err_addr = 32'h1;
    acc(0, 0, 32'h10C, '0, 4'h0, 1, o10c, 0, 0, "R7 cache unchanged");

    // R8 IO window bypass
    acc(0, 0, 32'hF000_0010, '0, 4'h0, 1, rd(32'hF000_0010), 0, 1, "R8 io read");
    acc(0, 0, 32'hF000_0010, '0, 4'h0, 1, rd(32'hF000_0010), 0, 1, "R8 io read again");
    acc(1, 0, 32'hF000_0010, 32'h5566_7788, 4'hF, 0, '0, 0, 1, "R8 io write");
    acc(0, 0, 32'hF000_0010, '0, 4'h0, 1, 32'h5566_7788, 0, 1, "R8 io fresh");
    // R12 IO read error
    err_addr = 32'hF000_0020;
    acc(0, 0, 32'hF000_0020, '0, 4'h0, 0, '0, 1, 1, "R12 io error");
    err_addr = 32'h1;

    // R10 set 2 holds 0x100 (way0); 0x140 and 0x1100 share the set
    acc(0, 0, 32'h140, '0, 4'h0, 1, rd(32'h140), 0, 16, "R10 second line");
    acc(0, 0, 32'h100, '0, 4'h0, 1, v100, 0, 0, "R10 both resident");
    acc(0, 0, 32'h1100, '0, 4'h0, 1, rd(32'h1100), 0, 16, "R10 third line");
    acc(0, 0, 32'h140, '0, 4'h0, 1, rd(32'h140), 0, 0, "R10 second kept");
    acc(0, 0, 32'h104, '0, 4'h0, 1, 32'hDEAD_BEEF, 0, 16, "R10 first evicted");

    // R11 fill error aborts, line stays invalid
    err_addr = 32'h3008;
    acc(0, 0, 32'h3004, '0, 4'h0, 0, '0, 1, 3, "R11 fill error");
    err_addr = 32'h1;
    acc(0, 0, 32'h3004, '0, 4'h0, 1, rd(32'h3004), 0, 16, "R11 refetch");

    finish_run();
  end
endmodule